// File: doc/BRIEF.md
# Synthesizer Divider Configuration Interface

This block holds the feedback divider value M (9 bits), the output divider code N (2 bits) and a 2-bit test selector for a PLL-based clock synthesizer. These settings can be programmed in two ways. A parallel path copies M and N straight from pins while an active-low parallel strobe is low, and it freezes them when that strobe rises. A serial path shifts a 14-bit frame in on rising serial-clock edges. The frame moves into the settings when a serial-load strobe rises. If that strobe is held high, every serial-clock edge writes the frame into the settings directly.

All pin inputs, including the two clocks that feed the test multiplexer, pass through two-flop synchronizers in a single fast system clock domain. The serial clock and both strobes are edge-detected in that domain, so the system clock must run well above the serial clock. The block also provides:
- the N code decoded into a one-hot divide ratio,
- a divider clear that follows the master reset pin,
- an informational flag for M values outside the range that locks with a 25 MHz reference,
- a TEST pin driven from one of four sources.

Top module: `synth_div_cfg`

## Requirements
- R1: While `par_load_n` is high, each rising `ser_clk` edge shifts `ser_data` into a 14-bit frame. The frame is sent in this order: T1, T0, one null bit, N1, N0, then M8 down to M0, with M0 sent last.
- R2: A rising edge of `ser_load` copies the frame into the settings: T from frame bits 13:12, N from bits 10:9 and M from bits 8:0. Frame bit 11 (the null slot) has no effect. The settings then hold after `ser_load` falls.
- R3: While `ser_load` is high, each rising `ser_clk` edge writes the newly shifted frame into M, N and T.
- R4: Settings do not change on serial clocks while `ser_load` is low. They also do not change on parallel pin changes while `par_load_n` is high.
- R5: While `par_load_n` is low, `m_val` and `n_code` follow `m_pins` and `n_pins`. The rising edge of `par_load_n` latches them. A later serial transfer overrides them, and a later low strobe replaces a serial setting.
- R6: The settings take effect three system clocks after the pin change that causes them.
- R7: `test_out` is 0 while `par_load_n` is low. Otherwise `t_sel` picks the source: 00 gives 0, 01 gives `ser_data`, 10 gives `fb_div_in` and 11 gives `synth_clk_in`. Every source goes through the two-flop synchronizer.
- R8: `div_ratio` is one-hot: 0001 for N=00, 0010 for N=01, 0100 for N=10 and 1000 for N=11.
- R9: `div_clear` follows `mr` through the synchronizer. Asserting `mr` leaves M, N and T unchanged.
- R10: After `rst`, M=20, N=00 and T=00.
- R11: `m_out_of_range` is high exactly when M is below 10 or above 28. It never blocks a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `ser_clk` |
| rst | input | 1 | Synchronous active-high power-on reset |
| mr | input | 1 | Master reset pin, active high |
| par_load_n | input | 1 | Parallel load strobe, active low |
| m_pins | input | 9 | Parallel M value |
| n_pins | input | 2 | Parallel N code |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial transfer strobe |
| fb_div_in | input | 1 | Feedback divider output, a source for the test multiplexer |
| synth_clk_in | input | 1 | Synthesized clock, a source for the test multiplexer |
| m_val | output | 9 | Active feedback divider value |
| n_code | output | 2 | Active output divider code |
| t_sel | output | 2 | Active test selector |
| div_ratio | output | 4 | One-hot output divide ratio |
| div_clear | output | 1 | Divider clear request |
| m_out_of_range | output | 1 | M is outside the range 10 to 28 |
| test_out | output | 1 | TEST pin |

## Verification
The bench sends frames whose null bit is random. A design that decoded the frame one slot off would show corrupted N or T fields, and the bench would catch it. Serial clocks sent after the load strobe falls must leave the settings unchanged; this exposes a design that keeps transferring once the strobe is low. The bench also runs the transparent strobe-high mode bit by bit, alternates the parallel and serial paths to confirm that each overrides the other, and probes M at 9, 10, 28 and 29 so that an off-by-one in the range flag shows up. The synchronized-clock sources of the TEST multiplexer are compared with the values their inputs had two system clocks earlier.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 2;
    localparam int NULL_W  = 1;
    localparam int FRAME_W = T_W + NULL_W + N_W + M_W;
    localparam int RATIO_W = 1 << N_W;

    typedef enum logic [T_W-1:0] {
        TSEL_LOW   = 2'd0,
        TSEL_SDATA = 2'd1,
        TSEL_FB    = 2'd2,
        TSEL_SYNTH = 2'd3
    } tsel_e;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } div_cfg_t;

    typedef struct packed {
        logic           mr;
        logic           par_n;
        logic           sload;
        logic           sclk;
        logic           sdata;
        logic           fb;
        logic           synth;
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } pin_bus_t;

    function automatic div_cfg_t frame_to_cfg(input logic [FRAME_W-1:0] f);
        div_cfg_t c;
        c.t = f[FRAME_W-1 -: T_W];
        c.n = f[M_W +: N_W];
        c.m = f[M_W-1:0];
        return c;
    endfunction

    function automatic logic [RATIO_W-1:0] ratio_onehot(input logic [N_W-1:0] n);
        return RATIO_W'(1) << n;
    endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/edge_det.sv
module edge_det #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= sig;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = sig[i] & ~prev[i];
        assign fall[i] = ~sig[i] & prev[i];
    end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);
    assign q_next = {q[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= q_next;
    end

    // R1: the frame moves only on a qualified serial clock edge
    assert_frame_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));
endmodule

// File: rtl/synth_div_cfg.sv
module synth_div_cfg
    import synth_cfg_pkg::*;
#(
    parameter int M_RESET = 20,
    parameter int M_LO    = 10,
    parameter int M_HI    = 28
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mr,
    input  logic               par_load_n,
    input  logic [M_W-1:0]     m_pins,
    input  logic [N_W-1:0]     n_pins,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_load,
    input  logic               fb_div_in,
    input  logic               synth_clk_in,
    output logic [M_W-1:0]     m_val,
    output logic [N_W-1:0]     n_code,
    output logic [T_W-1:0]     t_sel,
    output logic [RATIO_W-1:0] div_ratio,
    output logic               div_clear,
    output logic               m_out_of_range,
    output logic               test_out
);
    localparam int       PIN_W    = $bits(pin_bus_t);
    localparam pin_bus_t PIN_IDLE = '{mr: 1'b0, par_n: 1'b1, sload: 1'b0, sclk: 1'b0,
                                      sdata: 1'b0, fb: 1'b0, synth: 1'b0,
                                      m: '0, n: '0};
    localparam div_cfg_t CFG_RST  = '{t: '0, n: '0, m: M_W'(M_RESET)};

    pin_bus_t          raw_pins, syn;
    logic [PIN_W-1:0]  syn_vec;
    logic [2:0]        strobe_rise, strobe_fall;
    logic              par_rise, ld_rise, sclk_rise;
    logic              shift_en;
    logic [FRAME_W-1:0] frame_q, frame_next;
    div_cfg_t          cfg;

    assign raw_pins = '{mr: mr, par_n: par_load_n, sload: ser_load, sclk: ser_clk,
                        sdata: ser_data, fb: fb_div_in, synth: synth_clk_in,
                        m: m_pins, n: n_pins};

    pin_sync #(.W(PIN_W), .RST_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d(raw_pins), .q(syn_vec)
    );
    assign syn = pin_bus_t'(syn_vec);

    edge_det #(.W(3), .RST_VAL(3'b100)) u_edges (
        .clk(clk), .rst(rst),
        .sig({syn.par_n, syn.sload, syn.sclk}),
        .rise(strobe_rise), .fall(strobe_fall)
    );
    assign par_rise  = strobe_rise[2];
    assign ld_rise   = strobe_rise[1];
    assign sclk_rise = strobe_rise[0];

    assign shift_en = syn.par_n & sclk_rise;

    frame_shifter #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst(rst), .en(shift_en), .din(syn.sdata),
        .q(frame_q), .q_next(frame_next)
    );

    // Parallel strobe low wins; serial transfer edge next; then transparent mode.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RST;
        end else if (!syn.par_n) begin
            cfg.m <= syn.m;
            cfg.n <= syn.n;
        end else if (ld_rise) begin
            cfg <= frame_to_cfg(frame_q);
        end else if (syn.sload && shift_en) begin
            cfg <= frame_to_cfg(frame_next);
        end
    end

    always_comb begin
        test_out = 1'b0;
        if (syn.par_n) begin
            case (tsel_e'(cfg.t))
                TSEL_LOW:   test_out = 1'b0;
                TSEL_SDATA: test_out = syn.sdata;
                TSEL_FB:    test_out = syn.fb;
                TSEL_SYNTH: test_out = syn.synth;
                default:    test_out = 1'b0;
            endcase
        end
    end

    assign m_val          = cfg.m;
    assign n_code         = cfg.n;
    assign t_sel          = cfg.t;
    assign div_ratio      = ratio_onehot(cfg.n);
    assign div_clear      = syn.mr;
    assign m_out_of_range = (cfg.m < M_W'(M_LO)) || (cfg.m > M_W'(M_HI));

    assert_par_follow_R5: assert property (@(posedge clk) disable iff (rst)
        !syn.par_n |=> (m_val == $past(syn.m)) && (n_code == $past(syn.n)));

    assert_serial_xfer_R2: assert property (@(posedge clk) disable iff (rst)
        (syn.par_n && ld_rise) |=> cfg == $past(frame_to_cfg(frame_q)));

    assert_transparent_R3: assert property (@(posedge clk) disable iff (rst)
        (syn.par_n && !ld_rise && syn.sload && shift_en) |=> m_val == $past(frame_next[M_W-1:0]));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (syn.par_n && !ld_rise && !(syn.sload && sclk_rise)) |=> $stable(cfg));

    assert_latch_R5: assert property (@(posedge clk) disable iff (rst)
        (par_rise && !ld_rise && !syn.sload) |=> $stable(cfg));

    assert_ratio_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(div_ratio) && (div_ratio != '0));
endmodule

// File: tb/synth_div_cfg_tb.sv
module synth_div_cfg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mr = 1'b0, par_load_n = 1'b1, ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [8:0] m_pins = '0;
    logic [1:0] n_pins = '0;
    logic       fb_div_in = 1'b0, synth_clk_in = 1'b0;
    logic [8:0] m_val;
    logic [1:0] n_code, t_sel;
    logic [3:0] div_ratio;
    logic       div_clear, m_out_of_range, test_out;

    int vectors = 0, errors = 0;
    logic [13:0] sh = '0;
    logic [8:0]  em = 9'd20;
    logic [1:0]  en = 2'd0, et = 2'd0;
    logic [1:0]  fb_h = '0, sy_h = '0;
    int          tick = 0;

    always #5 clk = ~clk;

    synth_div_cfg u_dut (
        .clk(clk), .rst(rst), .mr(mr), .par_load_n(par_load_n), .m_pins(m_pins),
        .n_pins(n_pins), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
        .fb_div_in(fb_div_in), .synth_clk_in(synth_clk_in), .m_val(m_val),
        .n_code(n_code), .t_sel(t_sel), .div_ratio(div_ratio), .div_clear(div_clear),
        .m_out_of_range(m_out_of_range), .test_out(test_out)
    );

    // free-running feedback and synthesized toggles
    always @(negedge clk) begin
        tick <= tick + 1;
        synth_clk_in <= ~synth_clk_in;
        if (tick % 3 == 0) fb_div_in <= ~fb_div_in;
    end
    always @(posedge clk) begin
        fb_h <= {fb_h[0], fb_div_in};
        sy_h <= {sy_h[0], synth_clk_in};
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [3:0] exp_ratio(input logic [1:0] n);
        case (n)
            2'd0: return 4'b0001;
            2'd1: return 4'b0010;
            2'd2: return 4'b0100;
            default: return 4'b1000;
        endcase
    endfunction

    function automatic int exp_range(input logic [8:0] m);
        return (m < 9'd10 || m > 9'd28) ? 1 : 0;
    endfunction

    task automatic check_cfg(input string req);
        check({req, " m"}, m_val, em);
        check({req, " n"}, n_code, en);
        check({req, " t"}, t_sel, et);
        check("R8 ratio", div_ratio, exp_ratio(en));
        check("R11 range", m_out_of_range, exp_range(em));
    endtask

    task automatic ser_bit(input logic b);
        ser_data = b;
        idle(4);
        ser_clk = 1'b1;
        if (par_load_n) begin
            sh = {sh[12:0], b};
            if (ser_load) begin em = sh[8:0]; en = sh[10:9]; et = sh[13:12]; end
        end
        idle(4);
        ser_clk = 1'b0;
        idle(4);
    endtask

    task automatic send_frame(input logic [1:0] t, input logic nb, input logic [1:0] n, input logic [8:0] m);
        logic [13:0] f;
        f = {t, nb, n, m};
        for (int i = 13; i >= 0; i--) ser_bit(f[i]);
    endtask

    task automatic pulse_load();
        ser_load = 1'b1;
        em = sh[8:0]; en = sh[10:9]; et = sh[13:12];
        idle(6);
        ser_load = 1'b0;
        idle(6);
    endtask

    task automatic par_load(input logic [8:0] m, input logic [1:0] n);
        m_pins = m; n_pins = n;
        par_load_n = 1'b0;
        em = m; en = n;
        idle(5);
        check("R7 parallel test low", test_out, 0);
        check_cfg("R5 follow");
        par_load_n = 1'b1;
        idle(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle(5);
        rst = 1'b0;
        idle(2);
        // R10: reset defaults
        check_cfg("R10 reset");
        check("R10 test", test_out, 0);
        check("R9 clear idle", div_clear, 0);

        // R6: latency of three system clocks
        m_pins = 9'd13; n_pins = 2'd1;
        par_load_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R6 not yet", m_val, 20);
        @(negedge clk);
        check("R6 after three", m_val, 13);
        em = 9'd13; en = 2'd1;
        // R5: pins follow while low
        m_pins = 9'd17; em = 9'd17; idle(4);
        check_cfg("R5 follow2");
        par_load_n = 1'b1; idle(5);
        m_pins = 9'd300; n_pins = 2'd3; idle(5);
        check_cfg("R4 parallel pins ignored after latch");

        // R2: serial frame with null bit set, transfer on load
        send_frame(2'd2, 1'b1, 2'd2, 9'd25);
        check_cfg("R4 no transfer without load");
        pulse_load();
        check_cfg("R2 transfer");
        send_frame(2'd0, 1'b0, 2'd1, 9'd11);
        check_cfg("R4 hold after fall");

        // R5: parallel overrides serial; R2: serial overrides parallel
        par_load(9'd27, 2'd0);
        check_cfg("R5 override serial");
        pulse_load();
        check_cfg("R2 override parallel");

        // R3: transparent strobe-high mode
        ser_load = 1'b1; idle(6);
        em = sh[8:0]; en = sh[10:9]; et = sh[13:12];
        for (int i = 0; i < 14; i++) begin
            ser_bit(1'($urandom_range(0, 1)));
            check_cfg("R3 transparent");
        end
        ser_load = 1'b0; idle(6);
        ser_bit(1'b1);
        check_cfg("R4 after transparent");

        // R11: range edges
        par_load(9'd9, 2'd0);
        par_load(9'd10, 2'd1);
        par_load(9'd28, 2'd2);
        par_load(9'd29, 2'd3);

        // R7: test multiplexer
        send_frame(2'd1, 1'b0, 2'd0, 9'd20); pulse_load();
        ser_data = 1'b1; idle(4); check("R7 sdata 1", test_out, 1);
        ser_data = 1'b0; idle(4); check("R7 sdata 0", test_out, 0);
        send_frame(2'd2, 1'b1, 2'd1, 9'd21); pulse_load();
        for (int i = 0; i < 8; i++) begin @(negedge clk); check("R7 fb", test_out, fb_h[1]); end
        send_frame(2'd3, 1'b0, 2'd2, 9'd22); pulse_load();
        for (int i = 0; i < 8; i++) begin @(negedge clk); check("R7 synth", test_out, sy_h[1]); end
        send_frame(2'd0, 1'b1, 2'd3, 9'd23); pulse_load();
        for (int i = 0; i < 4; i++) begin @(negedge clk); check("R7 low", test_out, 0); end
        send_frame(2'd3, 1'b0, 2'd0, 9'd24); pulse_load();
        m_pins = em; n_pins = en; par_load_n = 1'b0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (i > 2) check("R7 parallel forces low", test_out, 0); end
        par_load_n = 1'b1; idle(5);

        // R9: master reset
        mr = 1'b1; idle(4);
        check("R9 clear high", div_clear, 1);
        check_cfg("R9 settings kept");
        mr = 1'b0; idle(4);
        check("R9 clear low", div_clear, 0);
        check_cfg("R9 settings kept after");

        // random mix
        for (int it = 0; it < 40; it++) begin
            case ($urandom_range(0, 2))
                0: par_load(9'($urandom_range(0, 511)), 2'($urandom_range(0, 3)));
                1: begin
                    send_frame(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                               2'($urandom_range(0, 3)), 9'($urandom_range(0, 511)));
                    check_cfg("R4 random no load");
                    pulse_load();
                    check_cfg("R2 random transfer");
                end
                default: begin
                    ser_load = 1'b1; idle(6);
                    em = sh[8:0]; en = sh[10:9]; et = sh[13:12];
                    for (int b = 0; b < 5; b++) ser_bit(1'($urandom_range(0, 1)));
                    check_cfg("R3 random transparent");
                    ser_load = 1'b0; idle(6);
                end
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule